// File: doc/BRIEF.md
# Programmable Time-Window Hit Classifier

This block watches a set of oversampled input wires, one sample per wire on every cycle of the sample clock, and decides in which of several time windows each wire saw a hit. A hit is a run of four consecutive high samples. A period is framed by a tick that is derived from a delayed reference clock. Sample positions inside a period count from zero at the tick. Window boundaries are given in units of `UNIT_SAMPLES` samples, which is 12 ns at a 1.2 ns sample spacing.

In the default mode there are six adjoining windows. In legacy mode there are three: prompt, not-sure and late. During a period the per-window flags accumulate. They are handed out, with a one-cycle valid pulse, at the tick that opens the next period. Each such word is also written into a small capture memory, tagged with a bit that says whether the configuration was legal. A test harness reads the memory back through a separate read port.

Top module: `hitwin_classifier`

## Requirements
- R1: A hit is recorded when a wire carries four consecutive high samples. A run of three or fewer highs records nothing. A longer run records exactly one hit.
- R2: A hit belongs to the window that holds the first of its four samples. Window k covers sample positions from S_k*UNIT_SAMPLES up to, but not including, S_(k+1)*UNIT_SAMPLES, and the last active window runs to the end of the period. Each S_k is the unsigned field `win_start[k*WIN_UNIT_W +: WIN_UNIT_W]`, and position 0 is the sample taken with `ref_tick` high.
- R3: A hit whose first sample lies before S_0*UNIT_SAMPLES sets no flag.
- R4: Several hits of one wire in one window set a single flag. At each tick, the flags of the period just closed are handed out and the accumulated flags are cleared, so a later period starts empty.
- R5: After the clock edge that samples `ref_tick` high, `flags_valid` is high for exactly one cycle and `flags_out` holds the flags of the period just ended. The flag for wire w and window k is bit w*6+k. The first tick after reset produces no valid pulse.
- R6: A hit whose first sample lies before the start of the period in which its fourth sample falls is dropped and sets no flag in any period.
- R7: When `legacy_mode` is 1, only S_0..S_2 are used and they form three windows: prompt, not-sure and late. Bits for windows 3..5 stay 0, and the values of S_3..S_5 have no effect, including on `cfg_err`.
- R8: If the active window starts are not strictly ascending, `cfg_err` rises one cycle after the configuration is applied. While it is set, every flag that is handed out is 0.
- R9: Each valid hand-out writes the word {legal bit, flags} into the capture memory. The legal bit is 1 when `cfg_err` was clear. Writes go to consecutive addresses starting at 0 after reset and wrap at the depth. `cap_rd_data` shows the entry at `cap_rd_addr` one cycle after the address is applied.
- R10: After reset, `flags_valid` is 0, `flags_out` is 0 and, with a legal configuration applied, `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per wire per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | High on the first sample of each period |
| legacy_mode | input | 1 | 1 selects three windows, 0 selects six |
| win_start | input | 6*WIN_UNIT_W | Window start values in sample units, window 0 in the low field |
| samples | input | N_WIRES | Current sample of each wire |
| flags_out | output | N_WIRES*6 | Per-wire, per-window flags of the last closed period |
| flags_valid | output | 1 | One-cycle pulse when `flags_out` is refreshed |
| cfg_err | output | 1 | Active window starts are not ascending |
| cap_rd_addr | input | log2(CAP_DEPTH) | Capture memory read address |
| cap_rd_data | output | N_WIRES*6+1 | Capture entry, legal bit in the top position |

## Verification
The window-assignment assertion relies on the configuration being legal. It is therefore switched off while `cfg_err` is set. The stimulus changes `win_start` and `legacy_mode` only after a period with no hits has been played, and it waits two idle cycles before the next tick. This ensures that no period is decoded under one configuration and handed out under another. The stimulus holds `ref_tick` high for a single cycle per period and keeps periods short enough that the position counter never saturates while hits are present.

// File: rtl/hitwin_pkg.sv
package hitwin_pkg;
  localparam int unsigned WIN_NEW    = 6;
  localparam int unsigned WIN_LEGACY = 3;
  localparam int unsigned RUN_LEN    = 4;

  typedef enum logic {
    MODE_SIX    = 1'b0,
    MODE_LEGACY = 1'b1
  } win_mode_e;
endpackage

// File: rtl/hitwin_run_detect.sv
module hitwin_run_detect #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_i,
  output logic hit_o
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run_q;

  // The hit fires on the sample that completes the run.
  assign hit_o = sample_i && (run_q == RW'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (!sample_i) begin
      run_q <= '0;
    end else if (run_q != RW'(RUN_LEN)) begin
      run_q <= run_q + RW'(1);
    end
  end

  AST_RUN_PRIOR_HIGH: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(sample_i)); // R1

  AST_ONE_HIT_PER_RUN: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o); // R1
endmodule

// File: rtl/hitwin_window_decode.sv
module hitwin_window_decode
  import hitwin_pkg::*;
#(
  parameter int unsigned POS_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hit_i,
  input  logic                     first_ok_i,
  input  logic [POS_W-1:0]         first_pos_i,
  input  logic [WIN_NEW*POS_W-1:0] lo_bound_i,
  input  win_mode_e                mode_i,
  input  logic                     cfg_bad_i,
  output logic [WIN_NEW-1:0]       win_o
);
  logic [WIN_NEW-1:0] at_or_above;
  logic [WIN_NEW-1:0] below_next;
  logic [WIN_NEW-1:0] active;
  logic [WIN_NEW-1:0] is_last;

  for (genvar k = 0; k < WIN_NEW; k++) begin : g_win
    assign at_or_above[k] = first_pos_i >= lo_bound_i[k*POS_W +: POS_W];
    assign active[k]  = (mode_i == MODE_LEGACY) ? (k < WIN_LEGACY) : 1'b1;
    assign is_last[k] = (mode_i == MODE_LEGACY) ? (k == WIN_LEGACY - 1)
                                                : (k == WIN_NEW - 1);
    if (k == WIN_NEW - 1) begin : g_top
      assign below_next[k] = 1'b1;
    end else begin : g_mid
      assign below_next[k] = !at_or_above[k+1];
    end
    assign win_o[k] = hit_i && first_ok_i && !cfg_bad_i && active[k] &&
                      at_or_above[k] && (is_last[k] || below_next[k]);
  end

  AST_SINGLE_WINDOW: assert property (@(posedge clk) disable iff (rst || cfg_bad_i)
    $onehot0(win_o)); // R2
endmodule

// File: rtl/hitwin_cfg_check.sv
module hitwin_cfg_check
  import hitwin_pkg::*;
#(
  parameter int unsigned WIN_UNIT_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WIN_NEW*WIN_UNIT_W-1:0] win_start_i,
  input  win_mode_e                     mode_i,
  output logic                          cfg_bad_o
);
  logic bad_c;

  always_comb begin
    bad_c = 1'b0;
    for (int k = 0; k < WIN_NEW - 1; k++) begin
      if ((mode_i == MODE_SIX) || (k + 1 < WIN_LEGACY)) begin
        if (win_start_i[(k+1)*WIN_UNIT_W +: WIN_UNIT_W] <=
            win_start_i[k*WIN_UNIT_W +: WIN_UNIT_W]) begin
          bad_c = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_bad_o <= 1'b0;
    else     cfg_bad_o <= bad_c;
  end
endmodule

// File: rtl/hitwin_capture.sv
module hitwin_capture #(
  parameter int unsigned DATA_W = 25,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;

  always_ff @(posedge clk) begin
    if (rst)          wr_ptr <= '0;
    else if (wr_en_i) wr_ptr <= wr_ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_ptr] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];
  end

  AST_CAP_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (wr_ptr == $past(wr_ptr) + AW'(1))); // R9
endmodule

// File: rtl/hitwin_classifier.sv
module hitwin_classifier
  import hitwin_pkg::*;
#(
  parameter int unsigned N_WIRES      = 4,
  parameter int unsigned WIN_UNIT_W   = 5,
  parameter int unsigned UNIT_SAMPLES = 10,
  parameter int unsigned POS_W        = 10,
  parameter int unsigned CAP_DEPTH    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ref_tick,
  input  logic                          legacy_mode,
  input  logic [WIN_NEW*WIN_UNIT_W-1:0] win_start,
  input  logic [N_WIRES-1:0]            samples,
  output logic [N_WIRES*WIN_NEW-1:0]    flags_out,
  output logic                          flags_valid,
  output logic                          cfg_err,
  input  logic [$clog2(CAP_DEPTH)-1:0]  cap_rd_addr,
  output logic [N_WIRES*WIN_NEW:0]      cap_rd_data
);
  localparam int unsigned FW    = N_WIRES * WIN_NEW;
  localparam int unsigned CW    = FW + 1;
  localparam int unsigned LEADS = RUN_LEN - 1;

  win_mode_e mode;
  assign mode = legacy_mode ? MODE_LEGACY : MODE_SIX;

  // Position of the current sample inside the period.
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] first_pos;
  logic             first_ok;
  logic             started_q;

  assign cur_pos   = ref_tick ? '0 : pos_q;
  assign first_ok  = cur_pos >= POS_W'(LEADS);
  assign first_pos = cur_pos - POS_W'(LEADS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      started_q <= 1'b0;
    end else begin
      pos_q     <= (cur_pos == '1) ? cur_pos : cur_pos + POS_W'(1);
      started_q <= started_q | ref_tick;
    end
  end

  // Window lower bounds in samples.
  logic [WIN_NEW*POS_W-1:0] lo_bound;
  for (genvar k = 0; k < WIN_NEW; k++) begin : g_bound
    assign lo_bound[k*POS_W +: POS_W] =
      POS_W'(win_start[k*WIN_UNIT_W +: WIN_UNIT_W]) * POS_W'(UNIT_SAMPLES);
  end

  hitwin_cfg_check #(
    .WIN_UNIT_W (WIN_UNIT_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .win_start_i (win_start),
    .mode_i      (mode),
    .cfg_bad_o   (cfg_err)
  );

  // Per-wire hit qualification and window assignment.
  logic [FW-1:0] new_bits;
  for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
    logic hit;

    hitwin_run_detect #(
      .RUN_LEN (RUN_LEN)
    ) u_run (
      .clk      (clk),
      .rst      (rst),
      .sample_i (samples[w]),
      .hit_o    (hit)
    );

    hitwin_window_decode #(
      .POS_W (POS_W)
    ) u_dec (
      .clk         (clk),
      .rst         (rst),
      .hit_i       (hit),
      .first_ok_i  (first_ok),
      .first_pos_i (first_pos),
      .lo_bound_i  (lo_bound),
      .mode_i      (mode),
      .cfg_bad_i   (cfg_err),
      .win_o       (new_bits[w*WIN_NEW +: WIN_NEW])
    );
  end

  // Sticky accumulation, cleared when a period closes.
  logic [FW-1:0] acc_q;
  logic [FW-1:0] closed_flags;
  logic          present;

  assign present      = ref_tick && started_q;
  assign closed_flags = cfg_err ? '0 : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      flags_out   <= '0;
      flags_valid <= 1'b0;
    end else begin
      acc_q       <= (ref_tick ? '0 : acc_q) | new_bits;
      flags_valid <= present;
      if (present) flags_out <= closed_flags;
    end
  end

  hitwin_capture #(
    .DATA_W (CW),
    .DEPTH  (CAP_DEPTH)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (present),
    .wr_data_i ({!cfg_err, closed_flags}),
    .rd_addr_i (cap_rd_addr),
    .rd_data_o (cap_rd_data)
  );

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    flags_valid |-> $past(ref_tick)); // R5

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    (flags_valid && $past(cfg_err)) |-> (flags_out == '0)); // R8
endmodule

// File: tb/hitwin_classifier_tb_top.sv
module hitwin_classifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW    = 4;
  localparam int NWIN  = 6;
  localparam int UW    = 5;
  localparam int USMP  = 10;
  localparam int PER   = 120;
  localparam int DEPTH = 16;
  localparam int FW    = NW * NWIN;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 ref_tick;
  logic                 legacy_mode;
  logic [NWIN*UW-1:0]   win_start;
  logic [NW-1:0]        samples;
  logic [FW-1:0]        flags_out;
  logic                 flags_valid;
  logic                 cfg_err;
  logic [3:0]           cap_rd_addr;
  logic [FW:0]          cap_rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  hitwin_classifier dut_i (
    .clk         (clk),
    .rst         (rst),
    .ref_tick    (ref_tick),
    .legacy_mode (legacy_mode),
    .win_start   (win_start),
    .samples     (samples),
    .flags_out   (flags_out),
    .flags_valid (flags_valid),
    .cfg_err     (cfg_err),
    .cap_rd_addr (cap_rd_addr),
    .cap_rd_data (cap_rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [NW-1:0] pat [PER];
  logic [UW-1:0] st [NWIN];
  bit            leg;
  logic [FW-1:0] exp_prev;
  string         req_prev;
  bit            have_prev = 1'b0;
  int            carry [NW];
  logic [FW:0]   capx [DEPTH];
  int            cap_cnt = 0;

  always_comb begin
    for (int k = 0; k < NWIN; k++) win_start[k*UW +: UW] = st[k];
    legacy_mode = leg;
  end

  function automatic bit cfg_bad();
    bit b = 1'b0;
    for (int k = 0; k < NWIN - 1; k++)
      if ((!leg || k + 1 < 3) && st[k+1] <= st[k]) b = 1'b1;
    return b;
  endfunction

  function automatic int win_of(int p);
    int n = leg ? 3 : NWIN;
    int r = -1;
    for (int k = 0; k < n; k++) if (p >= int'(st[k]) * USMP) r = k;
    return r;
  endfunction

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] expv);
    n_tests++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, expv);
    end
  endtask

  task automatic clear_pat();
    for (int i = 0; i < PER; i++) pat[i] = '0;
  endtask

  task automatic pulse(int w, int start, int len);
    for (int i = start; i < start + len && i < PER; i++) pat[i][w] = 1'b1;
  endtask

  // Plays one period; the tick checks the hand-out of the period before.
  task automatic play(string req);
    logic [FW-1:0] e = '0;
    int run;
    bit bad;
    for (int w = 0; w < NW; w++) begin
      run = carry[w];
      for (int i = 0; i < PER; i++) begin
        if (pat[i][w]) begin
          if (run == 3 && i - 3 >= 0 && win_of(i - 3) >= 0)
            e[w*NWIN + win_of(i - 3)] = 1'b1;
          if (run < 4) run++;
        end else begin
          run = 0;
        end
      end
      carry[w] = run;
    end
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      samples  = pat[i];
      ref_tick = (i == 0);
      @(posedge clk);
      #1;
      if (i == 0) begin
        if (have_prev) begin
          bad = cfg_bad();
          check(req_prev, "valid pulse", 64'(flags_valid), 64'd1);
          check(req_prev, "flags", 64'(flags_out), bad ? 64'd0 : 64'(exp_prev));
          capx[cap_cnt % DEPTH] = {!bad, bad ? {FW{1'b0}} : exp_prev};
          cap_cnt++;
        end else begin
          check("R5", "no valid on first tick", 64'(flags_valid), 64'd0);
        end
      end else if (i == 1 && have_prev) begin
        check("R5", "valid lasts one cycle", 64'(flags_valid), 64'd0);
      end
    end
    exp_prev  = e;
    req_prev  = req;
    have_prev = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      samples  = '0;
      ref_tick = 1'b0;
    end
    for (int w = 0; w < NW; w++) carry[w] = 0;
  endtask

  task automatic flush(string req);
    clear_pat();
    play(req);
  endtask

  task automatic set_cfg(bit l, int s0, int s1, int s2, int s3, int s4, int s5, string req);
    @(negedge clk);
    leg = l;
    st[0] = UW'(s0); st[1] = UW'(s1); st[2] = UW'(s2);
    st[3] = UW'(s3); st[4] = UW'(s4); st[5] = UW'(s5);
    idle(2);
    check(req, "cfg_err", 64'(cfg_err), 64'(cfg_bad()));
  endtask

  task automatic t_reset();
    check("R10", "flags_valid", 64'(flags_valid), 64'd0);
    check("R10", "flags_out", 64'(flags_out), 64'd0);
    check("R10", "cfg_err", 64'(cfg_err), 64'd0);
    flush("R5");
  endtask

  task automatic t_windows();
    clear_pat();
    pulse(0, 5, 4);
    pulse(1, 25, 4);
    pulse(2, 105, 4);
    pulse(3, 65, 4);
    play("R2");
    flush("R4");
  endtask

  task automatic t_boundary();
    clear_pat();
    pulse(0, 19, 4);
    pulse(1, 20, 4);
    pulse(2, 50, 3);
    pulse(3, 40, 12);
    play("R1");
    flush("R4");
  endtask

  task automatic t_sticky();
    clear_pat();
    pulse(0, 41, 4);
    pulse(0, 50, 5);
    pulse(1, 22, 4);
    pulse(1, 83, 6);
    play("R4");
    flush("R4");
  endtask

  task automatic t_carry();
    clear_pat();
    pulse(0, 118, 2);
    pulse(1, 116, 4);
    play("R6");
    clear_pat();
    pulse(0, 0, 2);
    play("R6");
    flush("R6");
  endtask

  task automatic t_before_first();
    set_cfg(1'b0, 3, 4, 5, 6, 7, 9, "R8");
    clear_pat();
    pulse(0, 10, 4);
    pulse(0, 30, 4);
    pulse(1, 95, 4);
    pulse(2, 29, 4);
    play("R3");
    flush("R3");
  endtask

  task automatic t_legacy();
    set_cfg(1'b1, 0, 4, 8, 1, 1, 1, "R7");
    clear_pat();
    pulse(0, 10, 4);
    pulse(1, 50, 4);
    pulse(2, 110, 4);
    pulse(3, 95, 4);
    play("R7");
    flush("R7");
  endtask

  task automatic t_error();
    set_cfg(1'b0, 0, 2, 4, 4, 8, 10, "R8");
    clear_pat();
    pulse(0, 5, 4);
    pulse(2, 70, 4);
    play("R8");
    flush("R8");
    set_cfg(1'b0, 0, 2, 4, 6, 8, 10, "R8");
    flush("R9");
  endtask

  task automatic t_capture();
    int idx;
    idle(1);
    for (int j = 1; j <= 5; j++) begin
      idx = (cap_cnt - j) % DEPTH;
      @(negedge clk);
      cap_rd_addr = 4'(idx);
      @(posedge clk);
      #1;
      check("R9", "capture entry", 64'(cap_rd_data), 64'(capx[idx]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    ref_tick = 1'b0;
    samples = '0;
    cap_rd_addr = '0;
    leg = 1'b0;
    for (int k = 0; k < NWIN; k++) st[k] = UW'(2 * k);
    for (int w = 0; w < NW; w++) carry[w] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_windows();
    t_boundary();
    t_sticky();
    t_carry();
    t_before_first();
    t_legacy();
    t_error();
    t_capture();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule